// File: doc/BRIEF.md
# Power-Gating Domain Sequencer

This controller steps one switchable logic domain between a powered state and an unpowered state while the surrounding always-on logic keeps running. It accepts single-cycle sleep and wake requests and drives the controls for that domain: the domain clock enable, the enable for the output isolation clamps, save and restore strobes for the retention flops, and the active-low control of the supply switch transistors. It also reports whether the domain is settled in a stable state.

Power-down is a fixed ordered chain. The clock is stopped first. Isolation is applied next, and the domain's outputs are then clamped to 0. State is saved into retention flops, which are fed from an always-on net. The switch is opened last. Power-up runs the chain the other way: the switch is closed, the controller waits a programmable number of cycles for the rail to settle, then restores state, restarts the clock, and finally releases isolation. Isolation acts only on the domain's outputs. A request that arrives while a chain is running is held until the chain finishes.

Top module: `pg_domain_seq`

## Requirements
- R1: After reset the outputs are dom_clk_en=1, iso_en=0, ret_save=0, ret_restore=0, pwr_sw_n=1 and ready=1 (domain powered).
- R2: A sleep request seen in the powered state starts power-down on the next edge. One step takes effect per cycle: first dom_clk_en drops, then iso_en rises, then ret_save pulses, then pwr_sw_n drops.
- R3: ret_save is high for exactly one cycle per power-down, and only while dom_clk_en=0, iso_en=1 and pwr_sw_n=1.
- R4: In the unpowered state the outputs hold at pwr_sw_n=0, iso_en=1, dom_clk_en=0, ready=1, no strobe, for as long as no wake request arrives.
- R5: A wake request seen in the unpowered state raises pwr_sw_n on the next edge. The settle wait then lasts exactly max(settle_cycles,1) cycles, with iso_en=1 and dom_clk_en=0 throughout.
- R6: After the settle wait, ret_restore is high for one cycle, then dom_clk_en rises while iso_en stays 1 for one cycle, then iso_en falls and the powered state is reached.
- R7: ready is 0 in every cycle of both sequences and 1 only in the powered and unpowered stable states.
- R8: A wake request that arrives during power-down is held. It is served in the cycle the unpowered state is reached, so that state lasts exactly one cycle.
- R9: A wake request while powered, or a sleep request while unpowered, is dropped and does not change any output. If both requests arrive in the same cycle while powered, sleep is served.
- R10: settle_cycles is sampled only in the cycle the wake request is served. Changes to it during the settle wait do not change the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Single-cycle request to power the domain down |
| wake_req | input | 1 | Single-cycle request to power the domain up |
| settle_cycles | input | SETTLE_W | Rail settle wait in cycles (0 is treated as 1) |
| dom_clk_en | output | 1 | Clock enable of the switchable domain |
| iso_en | output | 1 | Clamp the domain's outputs to 0 |
| ret_save | output | 1 | One-cycle strobe to save retention state |
| ret_restore | output | 1 | One-cycle strobe to restore retention state |
| pwr_sw_n | output | 1 | Supply switch control, low turns the domain off |
| ready | output | 1 | High when the domain is in a stable on or off state |

## Verification
Every output is decoded from the sequence state register, so a wrong state appears on the six control outputs in the cycle after the bad edge. The bench therefore compares the full output vector in every cycle of each sequence. A settle counter that loads the wrong value, or stops at the wrong count, shows up as the restore strobe arriving one or more cycles early or late. A held request that is lost or served twice shows up as the unpowered state lasting the wrong number of cycles, or as an unrequested sequence starting.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [3:0] {
    ST_ON      = 4'd0,
    ST_DN_CLK  = 4'd1,
    ST_DN_ISO  = 4'd2,
    ST_DN_SAVE = 4'd3,
    ST_OFF     = 4'd4,
    ST_UP_WAIT = 4'd5,
    ST_UP_REST = 4'd6,
    ST_UP_CLK  = 4'd7
  } pgs_state_e;
endpackage

// File: rtl/pgs_rst_sync.sv
module pgs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pgs_req_hold.sv
module pgs_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic at_stable,
  output logic sleep_pend,
  output logic wake_pend
);
  logic sleep_q, wake_q;
  logic sleep_d, wake_d;

  assign sleep_pend = sleep_q | sleep_req;
  assign wake_pend  = wake_q  | wake_req;

  always_comb begin
    sleep_d = sleep_pend & ~at_stable;
    wake_d  = wake_pend  & ~at_stable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      sleep_q <= sleep_d;
      wake_q  <= wake_d;
    end
  end

  // R8
  held_clears_at_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_stable |=> !(sleep_q || wake_q));
endmodule

// File: rtl/pgs_settle_tmr.sv
module pgs_settle_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         count_en,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                          cnt_d = load_val;
    else if (count_en && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q <= W'(1));

  // R10
  settle_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(rst_n)) |-> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/pg_domain_seq.sv
module pg_domain_seq
  import pgs_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic                wake_req,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                dom_clk_en,
  output logic                iso_en,
  output logic                ret_save,
  output logic                ret_restore,
  output logic                pwr_sw_n,
  output logic                ready
);
  logic       srst_n;
  pgs_state_e state_q, state_d;
  logic       sleep_pend, wake_pend, at_stable;
  logic       tmr_load, tmr_run, tmr_done;

  pgs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  assign at_stable = (state_q == ST_ON) || (state_q == ST_OFF);

  pgs_req_hold u_hold (
    .clk(clk), .rst_n(srst_n),
    .sleep_req(sleep_req), .wake_req(wake_req),
    .at_stable(at_stable),
    .sleep_pend(sleep_pend), .wake_pend(wake_pend)
  );

  assign tmr_load = (state_q == ST_OFF) && wake_pend;
  assign tmr_run  = (state_q == ST_UP_WAIT);

  pgs_settle_tmr #(.W(SETTLE_W)) u_tmr (
    .clk(clk), .rst_n(srst_n),
    .load(tmr_load), .load_val(settle_cycles),
    .count_en(tmr_run), .done(tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ON:      if (sleep_pend) state_d = ST_DN_CLK;
      ST_DN_CLK:  state_d = ST_DN_ISO;
      ST_DN_ISO:  state_d = ST_DN_SAVE;
      ST_DN_SAVE: state_d = ST_OFF;
      ST_OFF:     if (wake_pend) state_d = ST_UP_WAIT;
      ST_UP_WAIT: if (tmr_done) state_d = ST_UP_REST;
      ST_UP_REST: state_d = ST_UP_CLK;
      ST_UP_CLK:  state_d = ST_ON;
      default:    state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_ON;
    else         state_q <= state_d;
  end

  always_comb begin
    dom_clk_en  = 1'b0;
    iso_en      = 1'b1;
    ret_save    = 1'b0;
    ret_restore = 1'b0;
    pwr_sw_n    = 1'b1;
    ready       = 1'b0;
    unique case (state_q)
      ST_ON:      begin dom_clk_en = 1'b1; iso_en = 1'b0; ready = 1'b1; end
      ST_DN_CLK:  iso_en = 1'b0;
      ST_DN_ISO:  ;
      ST_DN_SAVE: ret_save = 1'b1;
      ST_OFF:     begin pwr_sw_n = 1'b0; ready = 1'b1; end
      ST_UP_WAIT: ;
      ST_UP_REST: ret_restore = 1'b1;
      ST_UP_CLK:  dom_clk_en = 1'b1;
      default:    ;
    endcase
  end

  // R2
  iso_after_clk_stop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(iso_en) |-> $past(!dom_clk_en));
  // R2
  sw_off_after_save_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(pwr_sw_n) |-> $past(ret_save));
  // R3
  save_when_frozen_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ret_save |-> (!dom_clk_en && iso_en && pwr_sw_n));
  // R3
  save_one_cycle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ret_save |=> !ret_save);
  // R4
  off_clamped_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !pwr_sw_n |-> (iso_en && !dom_clk_en));
  // R6
  restore_powered_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ret_restore |-> (pwr_sw_n && iso_en && !dom_clk_en));
  // R6
  iso_release_after_clk_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(iso_en) |-> $past(dom_clk_en));
  // R7
  strobe_not_ready_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ret_save || ret_restore) |-> !ready);
endmodule

// File: tb/pg_domain_seq_bench.sv
module pg_domain_seq_bench;
  localparam int SW = 8;
  // {dom_clk_en, iso_en, ret_save, ret_restore, pwr_sw_n, ready}
  localparam logic [5:0] V_ON   = 6'b100011;
  localparam logic [5:0] V_DCLK = 6'b000010;
  localparam logic [5:0] V_DISO = 6'b010010;
  localparam logic [5:0] V_DSAV = 6'b011010;
  localparam logic [5:0] V_OFF  = 6'b010001;
  localparam logic [5:0] V_WAIT = 6'b010010;
  localparam logic [5:0] V_REST = 6'b010110;
  localparam logic [5:0] V_UCLK = 6'b110010;

  logic clk = 1'b0;
  logic rst_n, sleep_req, wake_req;
  logic [SW-1:0] settle_cycles;
  logic dom_clk_en, iso_en, ret_save, ret_restore, pwr_sw_n, ready;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pg_domain_seq #(.SETTLE_W(SW)) u_pg_domain_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .settle_cycles(settle_cycles), .dom_clk_en(dom_clk_en), .iso_en(iso_en),
    .ret_save(ret_save), .ret_restore(ret_restore), .pwr_sw_n(pwr_sw_n),
    .ready(ready)
  );

  function automatic logic [5:0] obs();
    return {dom_clk_en, iso_en, ret_save, ret_restore, pwr_sw_n, ready};
  endfunction

  task automatic expect_v(input logic [5:0] exp, input string tag);
    n_tests++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, obs(), exp);
    end
  endtask

  task automatic go_down(input string tag);
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    expect_v(V_DCLK, {tag, " R2 clock stop"});
    @(negedge clk); expect_v(V_DISO, {tag, " R2 isolate"});
    @(negedge clk); expect_v(V_DSAV, {tag, " R3 save"});
    @(negedge clk); expect_v(V_OFF,  {tag, " R4 off"});
  endtask

  task automatic go_up(input int n, input bit disturb, input string tag);
    int eff;
    eff = (n == 0) ? 1 : n;
    @(negedge clk); wake_req = 1'b1; settle_cycles = SW'(n);
    @(negedge clk); wake_req = 1'b0;
    for (int i = 0; i < eff; i++) begin
      expect_v(V_WAIT, {tag, " R5 settle"});
      if (disturb) settle_cycles = (i % 2 == 0) ? SW'(1) : SW'(200);
      @(negedge clk);
    end
    expect_v(V_REST, {tag, " R6 restore"});
    @(negedge clk); expect_v(V_UCLK, {tag, " R6 clock on"});
    @(negedge clk); expect_v(V_ON,   {tag, " R6 on"});
  endtask

  task automatic t_reset();
    expect_v(V_ON, "R1 reset state");
    repeat (3) @(negedge clk);
    expect_v(V_ON, "R1 idle after reset");
  endtask

  task automatic t_down_hold();
    go_down("down");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); expect_v(V_OFF, "R4 off holds");
    end
  endtask

  task automatic t_sleep_in_off();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      expect_v(V_OFF, "R9 sleep while off ignored");
      @(negedge clk);
    end
  endtask

  task automatic t_wake_in_on();
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      expect_v(V_ON, "R9 wake while on ignored");
      @(negedge clk);
    end
  endtask

  task automatic t_both_on();
    @(negedge clk); wake_req = 1'b1; sleep_req = 1'b1;
    @(negedge clk); wake_req = 1'b0; sleep_req = 1'b0;
    expect_v(V_DCLK, "R9 sleep wins over wake");
    @(negedge clk); expect_v(V_DISO, "R2 both isolate");
    @(negedge clk); expect_v(V_DSAV, "R3 both save");
    @(negedge clk); expect_v(V_OFF,  "R4 both off");
    repeat (2) begin
      @(negedge clk); expect_v(V_OFF, "R9 dropped wake not served");
    end
  endtask

  task automatic t_held_wake();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    expect_v(V_DCLK, "R7 busy clock stop");
    @(negedge clk); expect_v(V_DISO, "R7 busy isolate");
    wake_req = 1'b1; settle_cycles = SW'(3);
    @(negedge clk); wake_req = 1'b0;
    expect_v(V_DSAV, "R8 save before held wake");
    @(negedge clk); expect_v(V_OFF, "R8 off one cycle");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); expect_v(V_WAIT, "R8 held wake settle");
    end
    @(negedge clk); expect_v(V_REST, "R8 restore");
    @(negedge clk); expect_v(V_UCLK, "R8 clock on");
    @(negedge clk); expect_v(V_ON,   "R8 on");
  endtask

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; settle_cycles = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_wake_in_on();
    t_down_hold();
    t_sleep_in_off();
    go_up(4, 1'b0, "wake4");
    go_down("down2");
    go_up(0, 1'b0, "wake0");
    go_down("down3");
    go_up(1, 1'b0, "wake1");
    go_down("down4");
    go_up(6, 1'b1, "R10 settle latched");
    t_both_on();
    go_up(20, 1'b0, "wake20");
    t_held_wake();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule